// File: doc/BRIEF.md
# Fast GPIO Port with Set/Clear Writes

This block is a general-purpose I/O port with one bit per pin. It sits on a fast local register bus where each access takes one cycle. Software chooses at run time whether each pin is an input or an output. It can change output levels in three ways: by writing the whole output register, by writing ones to a set register, or by writing ones to a clear register. The set and clear writes change any number of bits in one access, with no read-modify-write.

Reads can return the direction register or the stored output register. They can also return the pin levels as seen through a two-flop synchronizer, so software can compare what it asked for with what the pads really show.

Register word addresses are 0 direction, 1 output, 2 set, 3 clear and 4 pin state. Addresses 5 to 7 are unmapped.

Top module: `gpio_fastport`

## Requirements
- R1: While reset is active and after it is released, `pin_oe`, `pin_out` and `bus_rdata` are all zero, so every pin starts as an input.
- R2: A write to address 0 loads the direction register, and `pin_oe` equals it from the next cycle on. A direction bit of 1 means output and 0 means input.
- R3: A write to address 1 replaces every bit of the output register with the write data, and `pin_out` shows the new value from the next cycle.
- R4: A write to address 2 drives high each output bit whose write-data bit is 1. Bits written as 0 keep their value.
- R5: A write to address 3 drives low each output bit whose write-data bit is 1. Bits written as 0 keep their value.
- R6: `bus_rdata` is registered and shows the addressed register one cycle after the address is presented. Addresses 1, 2 and 3 all read the output register. A read captures the value held before any write made in the same cycle.
- R7: Address 4 reads the pin inputs through a two-flop synchronizer. A level applied before clock edge k reaches `bus_rdata` after edge k+2 when address 4 is held.
- R8: The pin-state read depends only on `pin_in`. It does not depend on the output register or the direction register.
- R9: Writes to address 4 or to the unmapped addresses 5 to 7 leave direction and output unchanged. Reads of unmapped addresses return zero.
- R10: Address 0 reads back the last value written to the direction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 3 | Register word address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Live pin levels |
| pin_out | output | 32 | Output register to pads |
| pin_oe | output | 32 | Per-pin output enable, 1 = drive |

## Verification
The bench writes set and clear masks over outputs that are already mixed. A design that wrongly clears unmasked bits on a set write, or sets them on a clear write, shows a `pin_out` that differs from the model. It reads address 1 in the same cycle as a write to address 1, which catches read data taken after the update rather than before it. It holds address 4 while `pin_in` changes, which exposes a synchronizer one stage too short or too long by a one-cycle shift in `bus_rdata`. It also writes to the pin-state address and to unmapped addresses to catch decode aliasing that would disturb the direction or output registers.

// File: rtl/gpio_fastport.sv
module gpio_fastport #(
  parameter int WIDTH = 32,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_we,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);
  localparam logic [AW-1:0] A_DIR = AW'(0);
  localparam logic [AW-1:0] A_OUT = AW'(1);
  localparam logic [AW-1:0] A_SET = AW'(2);
  localparam logic [AW-1:0] A_CLR = AW'(3);
  localparam logic [AW-1:0] A_PIN = AW'(4);

  logic [WIDTH-1:0] dir_q, out_q, sync1_q, sync2_q, rd_q;
  logic [WIDTH-1:0] out_nxt, rd_nxt;

  wire wr_dir = bus_we && (bus_addr == A_DIR);

  always_comb begin
    out_nxt = out_q;
    if (bus_we) begin
      unique case (bus_addr)
        A_OUT:   out_nxt = bus_wdata;
        A_SET:   out_nxt = out_q | bus_wdata;
        A_CLR:   out_nxt = out_q & ~bus_wdata;
        default: out_nxt = out_q;
      endcase
    end
  end

  always_comb begin
    unique case (bus_addr)
      A_DIR:               rd_nxt = dir_q;
      A_OUT, A_SET, A_CLR: rd_nxt = out_q;
      A_PIN:               rd_nxt = sync2_q;
      default:             rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      out_q   <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
      rd_q    <= '0;
    end else begin
      if (wr_dir) dir_q <= bus_wdata;
      out_q   <= out_nxt;
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      rd_q    <= rd_nxt;
    end
  end

  assign pin_out   = out_q;
  assign pin_oe    = dir_q;
  assign bus_rdata = rd_q;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (pin_oe == '0 && pin_out == '0 && bus_rdata == '0));

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_DIR) |=> pin_oe == $past(bus_wdata));

  // R3
  out_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_OUT) |=> pin_out == $past(bus_wdata));

  // R4
  set_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_SET) |=>
      ((pin_out & $past(bus_wdata)) == $past(bus_wdata)) &&
      ((pin_out & ~$past(bus_wdata)) == ($past(pin_out) & ~$past(bus_wdata))));

  // R5
  clr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_CLR) |=>
      ((pin_out & $past(bus_wdata)) == '0) &&
      ((pin_out & ~$past(bus_wdata)) == ($past(pin_out) & ~$past(bus_wdata))));

  // R9
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we || bus_addr >= A_PIN) |=> ($stable(pin_out) && $stable(pin_oe)));
endmodule

// File: tb/gpio_fastport_tb.sv
module gpio_fastport_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] pin_in = '0;
  logic [31:0] bus_rdata, pin_out, pin_oe;

  int checks = 0;
  int fails = 0;
  string phase = "R1";

  always #2.5 clk = ~clk;

  gpio_fastport u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  logic [31:0] m_dir = '0, m_out = '0, m_rd = '0;
  logic [31:0] m_pins[$] = '{32'h0, 32'h0};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dir = '0; m_out = '0; m_rd = '0;
      m_pins = '{32'h0, 32'h0};
    end else begin
      case (bus_addr)
        3'd0: m_rd = m_dir;
        3'd1, 3'd2, 3'd3: m_rd = m_out;
        3'd4: m_rd = m_pins[0];
        default: m_rd = '0;
      endcase
      if (bus_we) begin
        if (bus_addr == 3'd0) m_dir = bus_wdata;
        if (bus_addr == 3'd1) m_out = bus_wdata;
        if (bus_addr == 3'd2) m_out = m_out | bus_wdata;
        if (bus_addr == 3'd3) m_out = m_out & ~bus_wdata;
      end
      m_pins.push_back(pin_in);
      void'(m_pins.pop_front());
    end
  end

  task automatic check(string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got %h exp %h", phase, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    check("pin_oe", pin_oe, m_dir);
    check("pin_out", pin_out, m_out);
    check("bus_rdata", bus_rdata, m_rd);
  end

  task automatic acc(logic [2:0] a, logic w, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = w; bus_wdata = d;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      fails++;
      $display("FAIL watchdog expired got %0d exp below 20000", wd);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state observed during and after reset
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) acc(3'd0, 1'b0, '0);
    // R2 and R10 direction write and readback
    phase = "R2";
    acc(3'd0, 1'b1, 32'hF0F0_1234);
    phase = "R10";
    acc(3'd0, 1'b0, '0);
    acc(3'd0, 1'b0, '0);
    // R3 full replace
    phase = "R3";
    acc(3'd1, 1'b1, 32'hDEAD_BEEF);
    acc(3'd1, 1'b0, '0);
    // R4 set mask over mixed bits
    phase = "R4";
    acc(3'd2, 1'b1, 32'h0000_00FF);
    acc(3'd2, 1'b0, '0);
    acc(3'd2, 1'b1, 32'h0);
    // R5 clear mask
    phase = "R5";
    acc(3'd3, 1'b1, 32'hF000_000F);
    acc(3'd3, 1'b0, '0);
    acc(3'd3, 1'b1, 32'h0);
    // R6 read in same cycle as write returns old value
    phase = "R6";
    acc(3'd1, 1'b1, 32'h1234_5678);
    acc(3'd1, 1'b1, 32'hA5A5_5A5A);
    acc(3'd2, 1'b0, '0);
    acc(3'd3, 1'b0, '0);
    // R7 synchronizer latency with address held
    phase = "R7";
    acc(3'd4, 1'b0, '0);
    pin_in = 32'hCAFE_F00D;
    repeat (4) acc(3'd4, 1'b0, '0);
    pin_in = 32'h0000_0001;
    repeat (4) acc(3'd4, 1'b0, '0);
    // R8 pins differ from outputs and direction
    phase = "R8";
    acc(3'd0, 1'b1, 32'hFFFF_FFFF);
    acc(3'd1, 1'b1, 32'h0F0F_0F0F);
    pin_in = 32'h3C3C_3C3C;
    repeat (4) acc(3'd4, 1'b0, '0);
    // R9 writes to read-only and unmapped addresses
    phase = "R9";
    acc(3'd4, 1'b1, 32'hFFFF_FFFF);
    acc(3'd5, 1'b1, 32'h1111_1111);
    acc(3'd6, 1'b1, 32'h2222_2222);
    acc(3'd7, 1'b1, 32'h3333_3333);
    acc(3'd5, 1'b0, '0);
    acc(3'd0, 1'b0, '0);
    acc(3'd1, 1'b0, '0);
    // R4/R5 mixed random traffic
    phase = "R4/R5 random";
    for (int i = 0; i < 400; i++) begin
      pin_in = $urandom;
      acc(3'($urandom_range(0, 7)), 1'($urandom), $urandom);
    end
    acc(3'd0, 1'b0, '0);
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule